// File: doc/BRIEF.md
# Byte Bus Front-End with Power-Fail Lockout

This block sits between an asynchronous, SRAM-style byte bus and the internal storage of a timekeeping memory. The bus offers an active-low chip select, output enable and write enable, an address and a byte of data. The block turns these into single-clock read and write strobes for two targets. The highest sixteen addresses go to a small clock register file. Every lower address goes to a byte RAM array. The block also produces the enable that drives the external data bus during reads.

All bus controls and the power-fail input are asynchronous. They pass through two-flop synchronisers. Address and write data pass through a matching two-stage delay, so that all bus fields stay aligned in the system clock domain.

A write is committed once, when it ends. It uses the address and data held in the last synchronised cycle in which both chip select and write enable were active. While power fail is asserted, the block never drives the bus and never commits anything. A write that power fail interrupts is dropped. After power fail clears, the bus must show chip select inactive at least once before any new access is accepted.

Top module: `sbus_frontend`

## Requirements
- R1: While chip select is inactive, `bus_drive` is 0 and no read or write strobe is asserted, whatever the states of output enable and write enable.
- R2: While chip select and write enable are both active, the cycle is a write whether output enable is active or not. Once write enable is seen active, `bus_drive` is 0 even if output enable was already active.
- R3: While chip select and output enable are active and write enable is inactive, `bus_drive` is 1 and `bus_dout` carries the byte the selected target returns for the current address.
- R4: While chip select is active and both output enable and write enable are inactive, `bus_drive` stays 0.
- R5: Each write produces exactly one commit. The commit is a single-cycle pulse on `wr_ram` or `wr_reg`, with `wr_addr` and `wr_data` equal to the address and data held at the end of the write. The pulse appears no more than four clock cycles after the raw deassertion of write enable or chip select.
- R6: An address at or above 2^ADDR_W − 16 selects the register file; its register index is the low four address bits. Any other address selects the RAM. `rd_ram`/`rd_reg` and `wr_ram`/`wr_reg` follow this split, and at most one write strobe is high at a time.
- R7: While power fail is asserted, `bus_drive` is 0 and no write commit occurs.
- R8: A write still in progress when power fail asserts is aborted. It produces no commit, and the targeted location keeps its earlier value.
- R9: After power fail deasserts, no access is accepted until chip select has been seen inactive at least once. A chip select held active across the power-fail event stays ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Chip select, active low, asynchronous |
| bus_oe_n | input | 1 | Output enable, active low, asynchronous |
| bus_we_n | input | 1 | Write enable, active low, asynchronous |
| bus_addr | input | ADDR_W | Byte address |
| bus_din | input | DATA_W | Write data from the bus |
| pwr_fail | input | 1 | Power-fail indication, active high, asynchronous |
| bus_dout | output | DATA_W | Read data toward the bus |
| bus_drive | output | 1 | Enables the external data-bus drivers |
| rd_ram | output | 1 | RAM read select |
| rd_reg | output | 1 | Register-file read select |
| rd_addr | output | ADDR_W | Read address (aligned with the synchronised controls) |
| ram_rdata | input | DATA_W | Data returned by the RAM for `rd_addr` |
| reg_rdata | input | DATA_W | Data returned by the register file for `rd_addr` |
| wr_ram | output | 1 | One-cycle RAM write commit |
| wr_reg | output | 1 | One-cycle register-file write commit |
| wr_addr | output | ADDR_W | Commit address |
| wr_data | output | DATA_W | Commit data |

## Verification
The assertions assume that address and write data on the bus stay stable while the controls are active. They also assume these fields stay stable for at least three clock cycles after a control deasserts, so the two-stage data delay stays aligned with the synchronised controls. The bench changes inputs only at falling edges and holds every bus phase for four cycles or more. Each phase therefore settles through the synchronisers before the next one begins. Power fail is likewise held for several cycles at a time, so each assertion and release is seen as a clean level by the synchronised logic.

// File: rtl/sbus_frontend.sv
module sbus_frontend #(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int REG_SLOTS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  input  logic              pwr_fail,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_drive,
  output logic              rd_ram,
  output logic              rd_reg,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              wr_ram,
  output logic              wr_reg,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam logic [ADDR_W-1:0] REG_BASE = ADDR_W'((1 << ADDR_W) - REG_SLOTS);

  // control order: {pf, oe, we, cs}, active high after inversion
  logic [3:0] ctl_s1, ctl_s2;
  logic [ADDR_W-1:0] a_s1, a_s2;
  logic [DATA_W-1:0] d_s1, d_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_s1 <= '0;
      ctl_s2 <= '0;
      a_s1   <= '0;
      a_s2   <= '0;
      d_s1   <= '0;
      d_s2   <= '0;
    end else begin
      ctl_s1 <= {pwr_fail, ~bus_oe_n, ~bus_we_n, ~bus_cs_n};
      ctl_s2 <= ctl_s1;
      a_s1   <= bus_addr;
      a_s2   <= a_s1;
      d_s1   <= bus_din;
      d_s2   <= d_s1;
    end
  end

  logic cs_q, we_q, oe_q, pf_q;
  assign cs_q = ctl_s2[0];
  assign we_q = ctl_s2[1];
  assign oe_q = ctl_s2[2];
  assign pf_q = ctl_s2[3];

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed <= 1'b0;
    else if (pf_q)  armed <= 1'b0;
    else if (!cs_q) armed <= 1'b1;
  end

  logic sel_ok, wr_act, rd_act, addr_top;
  assign sel_ok   = armed & ~pf_q & cs_q;
  assign wr_act   = sel_ok & we_q;
  assign rd_act   = sel_ok & oe_q & ~we_q;
  assign addr_top = (a_s2 >= REG_BASE);

  assign rd_addr   = a_s2;
  assign rd_ram    = rd_act & ~addr_top;
  assign rd_reg    = rd_act & addr_top;
  assign bus_drive = rd_act;
  assign bus_dout  = addr_top ? reg_rdata : ram_rdata;

  logic              wr_act_d;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data;
  logic              wr_end;
  assign wr_end = wr_act_d & ~wr_act & ~pf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_d <= 1'b0;
      lat_addr <= '0;
      lat_data <= '0;
      wr_ram   <= 1'b0;
      wr_reg   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_act_d <= wr_act;
      if (wr_act) begin
        lat_addr <= a_s2;
        lat_data <= d_s2;
      end
      wr_ram <= 1'b0;
      wr_reg <= 1'b0;
      if (wr_end) begin
        wr_ram  <= (lat_addr < REG_BASE);
        wr_reg  <= (lat_addr >= REG_BASE);
        wr_addr <= lat_addr;
        wr_data <= lat_data;
      end
    end
  end

  assert_one_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_ram, wr_reg}));

  assert_route_ram_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ram |-> (wr_addr < REG_BASE));

  assert_commit_at_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ram || wr_reg) |-> ($past(wr_act_d) && !$past(wr_act)));

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ram || wr_reg) |=> !(wr_ram || wr_reg));

  assert_no_drive_in_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we_q |-> !bus_drive);

  assert_no_commit_in_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pf_q) |-> !(wr_ram || wr_reg));

  assert_float_in_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pf_q |-> !(bus_drive || rd_ram || rd_reg));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_q |-> !(bus_drive || rd_ram || rd_reg));

  assert_rearm_needs_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pf_q) && cs_q) |-> !bus_drive);
endmodule

// File: tb/sbus_frontend_tb_top.sv
module sbus_frontend_tb_top;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int NADDR = 1 << AW;
  localparam int BASE = NADDR - 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, pf = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout, ram_rdata, reg_rdata, wdata;
  logic drive, rram, rreg, wram, wreg;
  logic [AW-1:0] raddr, waddr;

  sbus_frontend #(.ADDR_W(AW), .DATA_W(DW), .REG_SLOTS(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .bus_addr(addr), .bus_din(din), .pwr_fail(pf), .bus_dout(dout), .bus_drive(drive),
    .rd_ram(rram), .rd_reg(rreg), .rd_addr(raddr), .ram_rdata(ram_rdata), .reg_rdata(reg_rdata),
    .wr_ram(wram), .wr_reg(wreg), .wr_addr(waddr), .wr_data(wdata));

  logic [DW-1:0] ramm [NADDR];
  logic [DW-1:0] regm [16];
  assign ram_rdata = ramm[raddr];
  assign reg_rdata = regm[raddr[3:0]];

  always @(posedge clk) begin
    if (wram) ramm[waddr] <= wdata;
    if (wreg) regm[waddr[3:0]] <= wdata;
  end

  int n_ram = 0, n_reg = 0, n_strobe_seen = 0;
  always @(negedge clk) begin
    if (wram) n_ram++;
    if (wreg) n_reg++;
    if (wram || wreg || rram || rreg) n_strobe_seen++;
  end

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 7 + 3 + k * 29) & 8'hff);
  endfunction

  task automatic bus_write(input int a, input int d, input bit oe_low);
    @(negedge clk);
    addr = AW'(a); din = DW'(d); cs_n = 1'b0; oe_n = ~oe_low; we_n = 1'b0;
    idle(4);
    we_n = 1'b1;
    idle(4);
    cs_n = 1'b1; oe_n = 1'b1;
    idle(4);
  endtask

  task automatic bus_read(input int a, output int d, output int drv);
    @(negedge clk);
    addr = AW'(a); cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    idle(4);
    d = int'(dout); drv = int'(drive);
    cs_n = 1'b1; oe_n = 1'b1;
    idle(4);
  endtask

  initial begin
    int d, drv, r0, g0, s0;
    for (int i = 0; i < NADDR; i++) ramm[i] = '0;
    for (int i = 0; i < 16; i++) regm[i] = '0;
    idle(3);
    // R1: reset state
    chk("R1 reset drive", int'(drive), 0);
    chk("R1 reset strobes", int'(wram | wreg | rram | rreg), 0);
    rst_n = 1'b1;
    idle(4);

    // R1: cs inactive with oe and we low
    s0 = n_strobe_seen;
    oe_n = 1'b0; we_n = 1'b0; idle(6);
    chk("R1 idle drive", int'(drive), 0);
    chk("R1 idle strobes", n_strobe_seen - s0, 0);
    oe_n = 1'b1; we_n = 1'b1; idle(4);

    // R4: cs active only
    cs_n = 1'b0; idle(6);
    chk("R4 cs only drive", int'(drive), 0);
    cs_n = 1'b1; idle(4);

    // R5/R6/R3: full sweep write then read
    for (int a = 0; a < NADDR; a++) begin
      r0 = n_ram; g0 = n_reg;
      bus_write(a, pat(a, 0), 1'b0);
      chk("R5 one commit", (n_ram - r0) + (n_reg - g0), 1);
      chk("R6 routing", n_reg - g0, (a >= BASE) ? 1 : 0);
    end
    for (int a = 0; a < NADDR; a++) begin
      bus_read(a, d, drv);
      chk("R3 read drive", drv, 1);
      chk("R3 read data", d, int'(pat(a, 0)));
    end

    // R2: write with oe already active, drivers off during write
    @(negedge clk);
    addr = AW'(9); din = 8'h5c; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    idle(4);
    chk("R2 read before write drive", int'(drive), 1);
    we_n = 1'b0; idle(4);
    chk("R2 drive off in write", int'(drive), 0);
    we_n = 1'b1; oe_n = 1'b1; idle(4);
    cs_n = 1'b1; idle(4);
    bus_read(9, d, drv);
    chk("R2 write with oe committed", d, 8'h5c);
    r0 = n_ram; g0 = n_reg;
    bus_write(BASE + 3, 8'hc3, 1'b1);
    bus_read(BASE + 3, d, drv);
    chk("R2 reg write with oe", d, 8'hc3);
    chk("R6 reg write count", n_reg - g0, 1);

    // R7: power fail blocks everything
    pf = 1'b1; idle(4);
    r0 = n_ram; g0 = n_reg;
    bus_write(12, 8'hee, 1'b0);
    bus_write(BASE + 1, 8'hee, 1'b0);
    bus_read(12, d, drv);
    chk("R7 no drive", drv, 0);
    chk("R7 no commit", (n_ram - r0) + (n_reg - g0), 0);
    pf = 1'b0; idle(6);
    bus_read(12, d, drv);
    chk("R7 ram unchanged", d, int'(pat(12, 0)));
    bus_read(BASE + 1, d, drv);
    chk("R7 reg unchanged", d, int'(pat(BASE + 1, 0)));

    // R8: write aborted by power fail
    r0 = n_ram; g0 = n_reg;
    @(negedge clk);
    addr = AW'(5); din = 8'haa; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    idle(4);
    pf = 1'b1; idle(4);
    we_n = 1'b1; cs_n = 1'b1; idle(4);
    pf = 1'b0; idle(6);
    chk("R8 no commit", (n_ram - r0) + (n_reg - g0), 0);
    bus_read(5, d, drv);
    chk("R8 old value kept", d, int'(pat(5, 0)));

    // R9: cs held across power fail stays ignored until seen idle
    @(negedge clk);
    addr = AW'(7); cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    idle(5);
    pf = 1'b1; idle(5);
    pf = 1'b0; idle(8);
    chk("R9 held cs ignored", int'(drive), 0);
    cs_n = 1'b1; idle(4);
    cs_n = 1'b0; idle(4);
    chk("R9 rearmed drive", int'(drive), 1);
    chk("R9 rearmed data", int'(dout), int'(pat(7, 0)));
    cs_n = 1'b1; oe_n = 1'b1; idle(4);

    // R5: second sweep with new data over all addresses
    for (int a = 0; a < NADDR; a++) bus_write(a, pat(a, 1), 1'b0);
    for (int a = 0; a < NADDR; a++) begin
      bus_read(a, d, drv);
      chk("R5 rewrite data", d, int'(pat(a, 1)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule